// File: doc/BRIEF.md
# DMA Modulo Address Generator

This block produces the source address sequence for a single DMA channel. A load strobe captures the channel's descriptor fields: a start address, a signed step, a wrap width, a transfer-size code, and a minor-loop adjustment with its enable. Each completed source read then advances the address by the sign-extended step. A nonzero wrap width N lets only the low N address bits change. The upper bits keep their value from before the add, so the address stream circles inside a power-of-two buffer.

When a minor loop completes and the adjustment is enabled, a second signed offset is added. The same wrap window also limits that add. If the read-done and minor-loop-done pulses arrive together, the step is applied first and the adjustment second. The size code is decoded into bytes per beat and beats per transfer. A reserved size code raises a configuration error and keeps the channel from starting.

The descriptor fields have no reset value, so software must load the block before it relies on it. The interface is pulse based and has no back-pressure. Each pulse is acted on in the cycle it is sampled, and the new address shows on `addr` after that clock edge.

Top module: `dma_srcaddr_gen`

## Requirements
- R1: After reset, `addr` is 0 and both `active` and `cfg_err` are 0.
- R2: A `load` with a valid size code sets `addr` to `ld_addr`, sets `active` to 1 and sets `cfg_err` to 0. All of these show after the load edge.
- R3: With wrap width 0, each `rd_done` on an active channel sets `addr` to `addr` plus `ld_off` sign-extended to 32 bits, modulo 2^32.
- R4: With wrap width N from 1 to 31, a step changes only `addr[N-1:0]`. Those bits take the low N bits of the sum, and bits 31..N keep their value from before the add.
- R5: Size codes 3'b100, 3'b110 and 3'b111 are reserved. Loading one sets `cfg_err` to 1 and `active` to 0. While the channel is inactive, `rd_done` and `mloop_done` leave `addr` unchanged.
- R6: When the enable is 1, `mloop_done` adds `ld_mloff` sign-extended to 32 bits, limited by the same wrap window as R4. When the enable is 0, `mloop_done` leaves `addr` unchanged.
- R7: When `rd_done` and `mloop_done` arrive in the same cycle, the step is applied first and the minor-loop offset is applied to that result.
- R8: On an active channel, `beat_bytes` and `beats` decode the size code as follows. 000 gives 1/1, 001 gives 2/1, 010 gives 4/1, 011 gives 8/1, and 101 gives 8/4 (a 32-byte burst). Both outputs are 0 when the channel is inactive.
- R9: A `load` takes priority over `rd_done` and `mloop_done` in the same cycle. The address becomes `ld_addr` with no step applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture all descriptor fields |
| ld_addr | input | 32 | Start address |
| ld_off | input | 16 | Signed step per source read |
| ld_mod | input | 5 | Wrap width N (0 = no wrap) |
| ld_size | input | 3 | Transfer-size code |
| ld_mle | input | 1 | Minor-loop offset enable |
| ld_mloff | input | 20 | Signed minor-loop offset |
| rd_done | input | 1 | Pulse: a source read completed |
| mloop_done | input | 1 | Pulse: a minor loop completed |
| addr | output | 32 | Current source address |
| active | output | 1 | Channel loaded with a valid size code |
| cfg_err | output | 1 | Reserved size code was loaded |
| beat_bytes | output | 4 | Bytes per beat |
| beats | output | 4 | Beats per transfer |

## Verification
Every pulse updates `addr` at the next edge, so a wrong captured step, wrap width or enable shows on `addr` within one cycle of the first pulse that uses it. A wrong wrap mask is detected only when a sum carries or borrows across bit N. For that reason the stimulus includes directed window crossings, the 32-bit rollover and N = 31, along with long random pulse runs on random descriptors. A corrupted size decode shows on `active`, `cfg_err`, `beat_bytes` and `beats` one cycle after the load.

// File: rtl/srcaddr_pkg.sv
package srcaddr_pkg;
  localparam logic [2:0] SZ_B8    = 3'b000;
  localparam logic [2:0] SZ_B16   = 3'b001;
  localparam logic [2:0] SZ_B32   = 3'b010;
  localparam logic [2:0] SZ_B64   = 3'b011;
  localparam logic [2:0] SZ_BURST = 3'b101;

  function automatic logic size_ok(input logic [2:0] c);
    return (c == SZ_B8) || (c == SZ_B16) || (c == SZ_B32) ||
           (c == SZ_B64) || (c == SZ_BURST);
  endfunction

  function automatic logic [3:0] size_bytes(input logic [2:0] c);
    case (c)
      SZ_B8:    return 4'd1;
      SZ_B16:   return 4'd2;
      SZ_B32:   return 4'd4;
      SZ_B64:   return 4'd8;
      SZ_BURST: return 4'd8;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] size_beats(input logic [2:0] c);
    if (c == SZ_BURST) return 4'd4;
    if (size_ok(c)) return 4'd1;
    return 4'd0;
  endfunction
endpackage

// File: rtl/srcaddr_cfg.sv
module srcaddr_cfg
  import srcaddr_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int MOD_W = 5,
  parameter int ML_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] ld_off,
  input  logic [MOD_W-1:0] ld_mod,
  input  logic [2:0]       ld_size,
  input  logic             ld_mle,
  input  logic [ML_W-1:0]  ld_mloff,
  output logic [OFF_W-1:0] soff,
  output logic [MOD_W-1:0] smod,
  output logic             mle,
  output logic [ML_W-1:0]  mloff,
  output logic             active,
  output logic             cfg_err,
  output logic [3:0]       beat_bytes,
  output logic [3:0]       beats
);
  logic [2:0] size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cfg_err <= 1'b0;
      size_q  <= SZ_B8;
    end else if (load) begin
      active  <= size_ok(ld_size);
      cfg_err <= !size_ok(ld_size);
      size_q  <= ld_size;
    end
  end

  // descriptor fields carry no reset value
  always_ff @(posedge clk) begin
    if (load) begin
      soff  <= ld_off;
      smod  <= ld_mod;
      mle   <= ld_mle;
      mloff <= ld_mloff;
    end
  end

  always_comb begin
    beat_bytes = active ? size_bytes(size_q) : 4'd0;
    beats      = active ? size_beats(size_q) : 4'd0;
  end

  // R5: a reserved code reported at load leaves the channel stopped
  a_r5_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    load && !size_ok(ld_size) |=> cfg_err && !active);

  // R8: a four-beat transfer always moves 64-bit beats
  a_r8_burst_width: assert property (@(posedge clk) disable iff (!rst_n)
    active && beats == 4'd4 |-> beat_bytes == 4'd8);
endmodule

// File: rtl/srcaddr_step.sv
module srcaddr_step #(
  parameter int AW    = 32,
  parameter int OFF_W = 16,
  parameter int MOD_W = 5,
  parameter int ML_W  = 20
) (
  input  logic [AW-1:0]    cur,
  input  logic [OFF_W-1:0] soff,
  input  logic [MOD_W-1:0] smod,
  input  logic             mle,
  input  logic [ML_W-1:0]  mloff,
  input  logic             do_rd,
  input  logic             do_ml,
  output logic [AW-1:0]    nxt,
  output logic [AW-1:0]    mask
);
  localparam int MAXM = AW - 1;

  logic [MOD_W-1:0] m_eff;
  logic [AW-1:0]    soff_x, mloff_x, sum1, a1, sum2;

  generate
    if ((2 ** MOD_W) > AW) begin : g_clamp
      assign m_eff = (smod > MOD_W'(MAXM)) ? MOD_W'(MAXM) : smod;
    end else begin : g_pass
      assign m_eff = smod;
    end
  endgenerate

  assign soff_x  = {{(AW-OFF_W){soff[OFF_W-1]}}, soff};
  assign mloff_x = {{(AW-ML_W){mloff[ML_W-1]}}, mloff};

  always_comb begin
    mask = (m_eff == '0) ? '1 : ((AW'(1) << m_eff) - AW'(1));
    sum1 = cur + soff_x;
    a1   = do_rd ? ((cur & ~mask) | (sum1 & mask)) : cur;
    sum2 = a1 + mloff_x;
    nxt  = (do_ml && mle) ? ((a1 & ~mask) | (sum2 & mask)) : a1;
  end
endmodule

// File: rtl/dma_srcaddr_gen.sv
module dma_srcaddr_gen #(
  parameter int AW    = 32,
  parameter int OFF_W = 16,
  parameter int MOD_W = 5,
  parameter int ML_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    ld_addr,
  input  logic [OFF_W-1:0] ld_off,
  input  logic [MOD_W-1:0] ld_mod,
  input  logic [2:0]       ld_size,
  input  logic             ld_mle,
  input  logic [ML_W-1:0]  ld_mloff,
  input  logic             rd_done,
  input  logic             mloop_done,
  output logic [AW-1:0]    addr,
  output logic             active,
  output logic             cfg_err,
  output logic [3:0]       beat_bytes,
  output logic [3:0]       beats
);
  logic [OFF_W-1:0] soff;
  logic [MOD_W-1:0] smod;
  logic             mle;
  logic [ML_W-1:0]  mloff;
  logic [AW-1:0]    nxt, mask;
  logic             advance;

  srcaddr_cfg #(.OFF_W(OFF_W), .MOD_W(MOD_W), .ML_W(ML_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_off(ld_off), .ld_mod(ld_mod), .ld_size(ld_size),
    .ld_mle(ld_mle), .ld_mloff(ld_mloff),
    .soff(soff), .smod(smod), .mle(mle), .mloff(mloff),
    .active(active), .cfg_err(cfg_err),
    .beat_bytes(beat_bytes), .beats(beats)
  );

  srcaddr_step #(.AW(AW), .OFF_W(OFF_W), .MOD_W(MOD_W), .ML_W(ML_W)) u_step (
    .cur(addr), .soff(soff), .smod(smod), .mle(mle), .mloff(mloff),
    .do_rd(rd_done), .do_ml(mloop_done), .nxt(nxt), .mask(mask)
  );

  assign advance = active && (rd_done || mloop_done);

  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= ld_addr;
    else if (advance) addr <= nxt;
  end

  // R2 / R9: a load always lands its start address
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(ld_addr));

  // R4: bits outside the wrap window never move on a step
  a_r4_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load |=> ((addr ^ $past(addr)) & ~$past(mask)) == '0);

  // R5: an inactive channel holds its address
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !load |=> $stable(addr));

  // R6: a minor-loop pulse with the enable clear changes nothing
  a_r6_ml_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    active && !load && mloop_done && !rd_done && !mle |=> $stable(addr));
endmodule

// File: tb/tb_dma_srcaddr_gen.sv
`timescale 1ns/1ps
module tb_dma_srcaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [15:0] ld_off = '0;
  logic [4:0]  ld_mod = '0;
  logic [2:0]  ld_size = '0;
  logic        ld_mle = 1'b0;
  logic [19:0] ld_mloff = '0;
  logic        rd_done = 1'b0;
  logic        mloop_done = 1'b0;
  logic [31:0] addr;
  logic        active, cfg_err;
  logic [3:0]  beat_bytes, beats;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // model state
  logic [31:0] e_addr;
  logic        e_act, e_err, e_mle;
  logic [15:0] e_off;
  logic [4:0]  e_mod;
  logic [2:0]  e_size;
  logic [19:0] e_ml;

  always #2.5 clk = ~clk;

  dma_srcaddr_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr),
    .ld_off(ld_off), .ld_mod(ld_mod), .ld_size(ld_size), .ld_mle(ld_mle),
    .ld_mloff(ld_mloff), .rd_done(rd_done), .mloop_done(mloop_done),
    .addr(addr), .active(active), .cfg_err(cfg_err),
    .beat_bytes(beat_bytes), .beats(beats)
  );

  function automatic logic m_ok(input logic [2:0] s);
    return (s <= 3'd3) || (s == 3'd5);
  endfunction

  function automatic logic [3:0] m_bytes(input logic [2:0] s);
    case (s)
      3'd0: return 4'd1;
      3'd1: return 4'd2;
      3'd2: return 4'd4;
      3'd3, 3'd5: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [31:0] m_wrap(input logic [31:0] old,
      input logic [31:0] sum, input logic [4:0] n);
    logic [31:0] keep;
    if (n == 0) return sum;
    keep = 32'hFFFF_FFFF << n;
    return (old & keep) | (sum & ~keep);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus at a falling edge, check one full cycle later
  task automatic cyc(input logic ld, input logic [31:0] a, input logic [15:0] o,
      input logic [4:0] m, input logic [2:0] s, input logic me,
      input logic [19:0] ml, input logic rd, input logic mp);
    string tag;
    logic [31:0] t;
    load = ld; ld_addr = a; ld_off = o; ld_mod = m; ld_size = s;
    ld_mle = me; ld_mloff = ml; rd_done = rd; mloop_done = mp;
    if (ld) begin
      e_addr = a; e_off = o; e_mod = m; e_size = s; e_mle = me; e_ml = ml;
      e_act = m_ok(s); e_err = !m_ok(s);
      tag = (rd || mp) ? "R9" : (m_ok(s) ? "R2" : "R5");
    end else if (!e_act) begin
      tag = "R5";
    end else begin
      t = e_addr;
      if (rd) t = m_wrap(t, t + {{16{e_off[15]}}, e_off}, e_mod);
      if (mp && e_mle) t = m_wrap(t, t + {{12{e_ml[19]}}, e_ml}, e_mod);
      e_addr = t;
      if (rd && mp) tag = "R7";
      else if (mp) tag = "R6";
      else if (e_mod != 0) tag = "R4";
      else tag = "R3";
    end
    @(negedge clk);
    chk(tag, addr, e_addr);
    if (ld) begin
      chk(tag, {31'd0, active}, {31'd0, e_act});
      chk(tag, {31'd0, cfg_err}, {31'd0, e_err});
      chk("R8", {28'd0, beat_bytes}, e_act ? {28'd0, m_bytes(e_size)} : 32'd0);
      chk("R8", {28'd0, beats}, !e_act ? 32'd0 : (e_size == 3'd5 ? 32'd4 : 32'd1));
    end
  endtask

  task automatic pulse(input logic rd, input logic mp);
    cyc(1'b0, '0, '0, '0, '0, 1'b0, '0, rd, mp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", addr, 32'd0);
    chk("R1", {30'd0, active, cfg_err}, 32'd0);
    e_addr = '0; e_act = 0; e_err = 0;
    e_off = '0; e_mod = '0; e_size = '0; e_mle = 0; e_ml = '0;
    pulse(1'b1, 1'b1); // R5 inactive after reset: no motion

    // R2 / R3 linear stepping
    cyc(1, 32'h1000_0000, 16'd4, 5'd0, 3'd2, 0, '0, 0, 0);
    repeat (3) pulse(1, 0);
    chk("R3", addr, 32'h1000_000C);
    // R3 32-bit rollover
    cyc(1, 32'hFFFF_FFFC, 16'd8, 5'd0, 3'd3, 0, '0, 0, 0);
    pulse(1, 0);
    chk("R3", addr, 32'h0000_0004);
    // R3 negative step
    cyc(1, 32'h0000_0002, 16'hFFFC, 5'd0, 3'd0, 0, '0, 0, 0);
    pulse(1, 0);
    chk("R3", addr, 32'hFFFF_FFFE);

    // R4 circular window of 16 bytes
    cyc(1, 32'h2000_00F8, 16'd4, 5'd4, 3'd2, 0, '0, 0, 0);
    pulse(1, 0); pulse(1, 0);
    chk("R4", addr, 32'h2000_00F0);
    // R4 N=31 keeps bit 31
    cyc(1, 32'h8000_0000, 16'hFFFF, 5'd31, 3'd1, 0, '0, 0, 0);
    pulse(1, 0);
    chk("R4", addr, 32'hFFFF_FFFF);

    // R5 each reserved code
    for (int c = 4; c < 8; c++) begin
      if (c == 5) continue;
      cyc(1, 32'h3000_0000, 16'd4, 5'd0, 3'(c), 1, 20'd64, 0, 0);
      pulse(1, 0); pulse(0, 1); pulse(1, 1);
      chk("R5", addr, 32'h3000_0000);
    end

    // R8 each valid code
    for (int c = 0; c < 6; c++) begin
      if (c == 4) continue;
      cyc(1, 32'h4000_0000, 16'd1, 5'd0, 3'(c), 0, '0, 0, 0);
    end

    // R6 minor-loop offset inside a 32-byte window, and disabled
    cyc(1, 32'h5000_0010, 16'd8, 5'd5, 3'd3, 1, 20'hFFFF0, 0, 0);
    pulse(0, 1);
    chk("R6", addr, 32'h5000_0000);
    pulse(0, 1);
    chk("R6", addr, 32'h5000_0010);
    cyc(1, 32'h5000_0010, 16'd8, 5'd5, 3'd3, 0, 20'hFFFF0, 0, 0);
    pulse(0, 1);
    chk("R6", addr, 32'h5000_0010);

    // R7 step then adjust, crossing the window edge
    cyc(1, 32'h6000_0018, 16'd8, 5'd5, 3'd5, 1, 20'd4, 0, 0);
    pulse(1, 1);
    chk("R7", addr, 32'h6000_0004);

    // R9 load beats same-cycle pulses
    cyc(1, 32'h7000_0100, 16'd4, 5'd0, 3'd2, 1, 20'd16, 1, 1);
    chk("R9", addr, 32'h7000_0100);

    // random descriptors and pulse patterns
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 24) == 0) begin
        cyc(1, $urandom, 16'($urandom), 5'($urandom),
            3'($urandom), 1'($urandom), 20'($urandom),
            1'($urandom % 4 == 0), 1'($urandom % 4 == 0));
      end else begin
        pulse(1'($urandom % 3 != 0), 1'($urandom % 5 == 0));
      end
    end

    rd_done = 0; mloop_done = 0; load = 0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule